// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block is one stage of a display pixel pipeline for a framebuffer that mixes two colour sources. For every pixel it takes an 8-bit palette index, a 32-bit true-colour word and a 32-bit control word. The two 32-bit words arrive in their big-endian memory byte order. The block byte-swaps them and reads a tag byte from the control word. That tag decides, pixel by pixel, whether the 24-bit RGB output is the true-colour value or the palette entry picked by the index. Direct and indexed pixels can therefore sit next to each other on the same scanline.

Pixels enter and leave through a valid/ready handshake at up to one per cycle. For indexed pixels the block issues a read to an external palette RAM, which answers one cycle later. The direct colour is held in a pipeline register so that it lines up with that palette answer, and pixels leave in the order they arrived. A start-of-line flag and an end-of-frame flag travel alongside each pixel. When the downstream side stalls, the whole stage holds, including the palette read data, and no pixel is lost or repeated.

Top module: `cpx_sel`

## Requirements
- R1: While reset is asserted, and right after it is released, valid_o is 0 and ready_o is 1.
- R2: The tag byte is ctrl_word_i[7:0], the first byte in memory, which is bits 31:24 after the byte swap. A pixel is direct when this byte equals 8'h03. Bytes 31:8 of ctrl_word_i play no part in the choice.
- R3: For a direct pixel with true-colour word w, rgb_o = {w[15:8], w[23:16], w[31:24]}, which is red, green, blue after the byte swap. w[7:0] is ignored.
- R4: For any other tag, rgb_o is the palette entry at index_i. For such a pixel, pal_rd_o is high with pal_addr_o = index_i in the cycle the pixel is accepted, and in no other cycle. The palette answers on pal_data_i in the following cycle and holds that value until the next read.
- R5: Accepting a direct pixel issues no palette read.
- R6: Output pixels leave in input order, with direct and indexed pixels mixed freely.
- R7: sol_o and eof_o leave with the same pixel that carried sol_i and eof_i.
- R8: While valid_o is high and ready_i is low, valid_o, rgb_o, sol_o and eof_o hold steady. No pixel is dropped or duplicated.
- R9: ready_o is high whenever valid_o is low.
- R10: With the default output register, a pixel accepted at one clock edge appears on valid_o after the second edge, provided no stall occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input pixel valid |
| ready_o | output | 1 | Stage can accept a pixel |
| index_i | input | IDX_W | Palette index of the pixel |
| color_word_i | input | 32 | True-colour word, memory byte order |
| ctrl_word_i | input | 32 | Control-plane word, memory byte order |
| sol_i | input | 1 | Start-of-line marker |
| eof_i | input | 1 | End-of-frame marker |
| pal_rd_o | output | 1 | Palette read strobe |
| pal_addr_o | output | IDX_W | Palette read address |
| pal_data_i | input | 24 | Palette read data, one cycle after the strobe |
| valid_o | output | 1 | Output pixel valid |
| ready_i | input | 1 | Downstream accepts the pixel |
| rgb_o | output | 24 | Output colour, red in 23:16 |
| sol_o | output | 1 | Start-of-line marker of the output pixel |
| eof_o | output | 1 | End-of-frame marker of the output pixel |

## Verification
Directed pixels place the value 03 in each byte of the control word in turn. Only the first memory byte may select direct mode. Tags of 02 and 83 must fall back to the palette. Two direct words that differ only in their discarded byte must give the same colour, and distinct byte values in the true-colour word expose any swap or ordering mistake. Random streams mix direct and indexed pixels with random valid and ready. Comparing the output stream in order against bench-computed colours and markers shows whether the direct path is misaligned with the palette latency, whether data is lost under stall, and whether a pixel is repeated.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned RGB_W  = 24;
  localparam int unsigned BYTES  = WORD_W / 8;

  typedef logic [RGB_W-1:0] rgb_t;

  typedef struct packed {
    logic sol;
    logic eof;
    logic direct;
    rgb_t rgb;
  } beat_t;

  // memory byte order to register order
  function automatic logic [WORD_W-1:0] bswap(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < BYTES; b++) r[8*b +: 8] = w[8*(BYTES-1-b) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
  import cpx_pkg::*;
#(
  parameter logic [7:0] DIRECT_TAG = 8'h03
) (
  input  logic [WORD_W-1:0] ctrl_word_i,
  input  logic [WORD_W-1:0] color_word_i,
  output logic              direct_o,
  output rgb_t              rgb_o
);
  logic [WORD_W-1:0] ctrl_sw, color_sw;

  assign ctrl_sw  = bswap(ctrl_word_i);
  assign color_sw = bswap(color_word_i);
  assign direct_o = (ctrl_sw[WORD_W-1 -: 8] == DIRECT_TAG);
  assign rgb_o    = color_sw[RGB_W-1:0];
endmodule

// File: rtl/cpx_lookup_stage.sv
module cpx_lookup_stage
  import cpx_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  beat_t            in_beat_i,
  input  logic [IDX_W-1:0] index_i,
  output logic             s1_valid_o,
  output beat_t            s1_beat_o,
  input  logic             s1_ready_i,
  output logic             pal_rd_o,
  output logic [IDX_W-1:0] pal_addr_o
);
  logic  valid_q;
  beat_t beat_q;

  assign in_ready_o = !valid_q || s1_ready_i;
  // palette answers when this register loads; direct pixels skip the read
  assign pal_rd_o   = in_valid_i && in_ready_o && !in_beat_i.direct;
  assign pal_addr_o = index_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) beat_q <= in_beat_i;
    end
  end

  assign s1_valid_o = valid_q;
  assign s1_beat_o  = beat_q;
endmodule

// File: rtl/cpx_out_stage.sv
module cpx_out_stage
  import cpx_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  s1_valid_i,
  input  beat_t s1_beat_i,
  output logic  s1_ready_o,
  input  rgb_t  pal_data_i,
  output logic  valid_o,
  input  logic  ready_i,
  output rgb_t  rgb_o,
  output logic  sol_o,
  output logic  eof_o
);
  beat_t merged;

  always_comb begin
    merged = s1_beat_i;
    if (!s1_beat_i.direct) merged.rgb = pal_data_i;
  end

  if (OUT_REG) begin : g_reg
    logic  valid_q;
    beat_t beat_q;

    assign s1_ready_o = !valid_q || ready_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        beat_q  <= '0;
      end else if (s1_ready_o) begin
        valid_q <= s1_valid_i;
        if (s1_valid_i) beat_q <= merged;
      end
    end

    assign valid_o = valid_q;
    assign rgb_o   = beat_q.rgb;
    assign sol_o   = beat_q.sol;
    assign eof_o   = beat_q.eof;
  end else begin : g_pass
    assign s1_ready_o = ready_i;
    assign valid_o    = s1_valid_i;
    assign rgb_o      = merged.rgb;
    assign sol_o      = merged.sol;
    assign eof_o      = merged.eof;
  end
endmodule

// File: rtl/cpx_sel.sv
module cpx_sel
  import cpx_pkg::*;
#(
  parameter int unsigned IDX_W      = 8,
  parameter logic [7:0]  DIRECT_TAG = 8'h03,
  parameter bit          OUT_REG    = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [IDX_W-1:0] index_i,
  input  logic [31:0]      color_word_i,
  input  logic [31:0]      ctrl_word_i,
  input  logic             sol_i,
  input  logic             eof_i,
  output logic             pal_rd_o,
  output logic [IDX_W-1:0] pal_addr_o,
  input  logic [23:0]      pal_data_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [23:0]      rgb_o,
  output logic             sol_o,
  output logic             eof_o
);
  logic  direct;
  rgb_t  direct_rgb;
  beat_t in_beat, s1_beat;
  logic  s1_valid, s1_ready;

  cpx_decode #(.DIRECT_TAG(DIRECT_TAG)) u_decode (
    .ctrl_word_i (ctrl_word_i),
    .color_word_i(color_word_i),
    .direct_o    (direct),
    .rgb_o       (direct_rgb)
  );

  assign in_beat = '{sol: sol_i, eof: eof_i, direct: direct, rgb: direct_rgb};

  cpx_lookup_stage #(.IDX_W(IDX_W)) u_lookup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(valid_i),
    .in_ready_o(ready_o),
    .in_beat_i (in_beat),
    .index_i   (index_i),
    .s1_valid_o(s1_valid),
    .s1_beat_o (s1_beat),
    .s1_ready_i(s1_ready),
    .pal_rd_o  (pal_rd_o),
    .pal_addr_o(pal_addr_o)
  );

  cpx_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s1_valid_i(s1_valid),
    .s1_beat_i (s1_beat),
    .s1_ready_o(s1_ready),
    .pal_data_i(pal_data_i),
    .valid_o   (valid_o),
    .ready_i   (ready_i),
    .rgb_o     (rgb_o),
    .sol_o     (sol_o),
    .eof_o     (eof_o)
  );
endmodule

// File: rtl/cpx_sel_chk.sv
module cpx_sel_chk #(
  parameter int unsigned IDX_W      = 8,
  parameter logic [7:0]  DIRECT_TAG = 8'h03
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_o,
  input logic [IDX_W-1:0] index_i,
  input logic [31:0]      ctrl_word_i,
  input logic             pal_rd_o,
  input logic [IDX_W-1:0] pal_addr_o,
  input logic             valid_o,
  input logic             ready_i,
  input logic [23:0]      rgb_o,
  input logic             sol_o,
  input logic             eof_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && ready_o));

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(rgb_o) && $stable(sol_o) && $stable(eof_o)));

  // R5
  direct_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && ctrl_word_i[7:0] == DIRECT_TAG) |-> !pal_rd_o);

  // R4
  indexed_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && ctrl_word_i[7:0] != DIRECT_TAG) |-> (pal_rd_o && pal_addr_o == index_i));

  // R4
  read_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_rd_o |-> (valid_i && ready_o));

  // R9
  empty_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ready_o);
endmodule

bind cpx_sel cpx_sel_chk #(.IDX_W(IDX_W), .DIRECT_TAG(DIRECT_TAG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .index_i    (index_i),
  .ctrl_word_i(ctrl_word_i),
  .pal_rd_o   (pal_rd_o),
  .pal_addr_o (pal_addr_o),
  .valid_o    (valid_o),
  .ready_i    (ready_i),
  .rgb_o      (rgb_o),
  .sol_o      (sol_o),
  .eof_o      (eof_o)
);

// File: tb/cpx_sel_tb_top.sv
module cpx_sel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0, ready_i = 1'b0, sol_i = 1'b0, eof_i = 1'b0;
  logic [7:0]  index_i = '0;
  logic [31:0] color_word_i = '0, ctrl_word_i = '0;
  logic        ready_o, pal_rd_o, valid_o, sol_o, eof_o;
  logic [7:0]  pal_addr_o;
  logic [23:0] pal_data_i = '0, rgb_o;

  typedef struct {
    logic [23:0] rgb;
    logic        sol;
    logic        eof;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  logic        hold_pend = 1'b0;
  logic [25:0] hold_val;

  always #5 clk_i = ~clk_i;

  cpx_sel dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .index_i(index_i), .color_word_i(color_word_i), .ctrl_word_i(ctrl_word_i),
    .sol_i(sol_i), .eof_i(eof_i), .pal_rd_o(pal_rd_o), .pal_addr_o(pal_addr_o),
    .pal_data_i(pal_data_i), .valid_o(valid_o), .ready_i(ready_i),
    .rgb_o(rgb_o), .sol_o(sol_o), .eof_o(eof_o)
  );

  function automatic logic [23:0] pal_fn(input logic [7:0] a);
    return {a ^ 8'h5a, ~a, a + 8'd77};
  endfunction

  // palette RAM model: one-cycle read, holds between reads
  always @(posedge clk_i) if (pal_rd_o) pal_data_i <= pal_fn(pal_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic observe();
    exp_t e;
    bit   dir;
    if (hold_pend)
      chk(valid_o && {sol_o, eof_o, rgb_o} == hold_val, "R8 stall hold",
          {5'd0, valid_o, sol_o, eof_o, rgb_o}, {6'd1, hold_val});
    hold_pend = valid_o && !ready_i;
    hold_val  = {sol_o, eof_o, rgb_o};
    if (valid_o && ready_i) begin
      if (sb.size() == 0) chk(1'b0, "R6 unexpected pixel (R8 duplicate)", {8'd0, rgb_o}, 32'd0);
      else begin
        e = sb.pop_front();
        chk(rgb_o == e.rgb, e.req, {8'd0, rgb_o}, {8'd0, e.rgb});
        chk({sol_o, eof_o} == {e.sol, e.eof}, "R7 markers", {30'd0, sol_o, eof_o}, {30'd0, e.sol, e.eof});
      end
    end
    if (valid_i && ready_o) begin
      dir   = (ctrl_word_i[7:0] == 8'h03);
      e.rgb = dir ? {color_word_i[15:8], color_word_i[23:16], color_word_i[31:24]} : pal_fn(index_i);
      e.sol = sol_i;
      e.eof = eof_i;
      e.req = dir ? "R3 direct colour (R2 tag)" : "R4 palette colour (R2 tag)";
      sb.push_back(e);
      if (dir) chk(!pal_rd_o, "R5 no read for direct", {31'd0, pal_rd_o}, 32'd0);
      else chk(pal_rd_o && pal_addr_o == index_i, "R4 palette read",
               {23'd0, pal_rd_o, pal_addr_o}, {23'd1, index_i});
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] ix, input logic [31:0] cw,
                       input logic [31:0] tw, input logic s, input logic f, input logic rdy);
    valid_i = v; index_i = ix; ctrl_word_i = cw; color_word_i = tw;
    sol_i = s; eof_i = f; ready_i = rdy;
    #1;
    observe();
    @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!valid_o && ready_o, "R1 reset state", {30'd0, valid_o, ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && ready_o, "R1 after release", {30'd0, valid_o, ready_o}, 32'd1);

    // R10 latency: one direct pixel into an empty stage
    drive(1, 8'h10, 32'h0000_0003, 32'hA1B2_C3D4, 1, 0, 1);
    chk(!valid_o, "R10 not after one edge", {31'd0, valid_o}, 32'd0);
    drive(0, 0, 0, 0, 0, 0, 1);
    chk(valid_o && rgb_o == 24'hC3B2A1, "R10 out after two edges / R3", {7'd0, valid_o, rgb_o}, {8'd1, 24'hC3B2A1});
    drive(0, 0, 0, 0, 0, 0, 1);

    // R2 tag position and values, R3 ignored byte
    drive(1, 8'h21, 32'h0300_0000, 32'h1122_3344, 1, 0, 1);
    drive(1, 8'h22, 32'h0003_0000, 32'h1122_3344, 0, 0, 1);
    drive(1, 8'h23, 32'h0000_0300, 32'h1122_3344, 0, 0, 1);
    drive(1, 8'h24, 32'hFFFF_FF03, 32'h1122_33AA, 0, 0, 1);
    drive(1, 8'h25, 32'h0000_0003, 32'h1122_3355, 0, 0, 1);
    drive(1, 8'h26, 32'h0000_0002, 32'h1122_3344, 0, 0, 1);
    drive(1, 8'h27, 32'h0000_0083, 32'h1122_3344, 0, 1, 1);
    repeat (4) drive(0, 0, 0, 0, 0, 0, 1);

    // R6 alternating sources back to back, R8 long stall
    for (int i = 0; i < 8; i++)
      drive(1, 8'(i * 37), (i % 2 == 0) ? 32'h3 : 32'h0, {8'(i), 8'hC0, 8'h0F, 8'hEE}, i == 0, i == 7, 1);
    for (int i = 0; i < 6; i++)
      drive(1, 8'(200 + i), (i % 3 == 0) ? 32'h3 : 32'h1, {8'(i * 5), 8'h77, 8'h99, 8'h00}, 0, 0, 0);
    repeat (5) drive(0, 0, 0, 0, 0, 0, 0);
    repeat (6) drive(0, 0, 0, 0, 0, 0, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] cw;
      cw = $urandom();
      if ($urandom_range(1, 0) == 1) cw[7:0] = 8'h03;
      drive($urandom_range(9, 0) < 7, 8'($urandom()), cw, $urandom(),
            $urandom_range(15, 0) == 0, $urandom_range(31, 0) == 0, $urandom_range(9, 0) < 6);
    end
    repeat (8) drive(0, 0, 0, 0, 0, 0, 1);
    chk(sb.size() == 0 && !valid_o, "R8 no pixel dropped / R6", sb.size(), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule